// File: doc/BRIEF.md
# Prescaled Timebase with Edge Capture

This block keeps a free-running 8-bit timebase that advances once per prescaled tick and wraps after 250 counts. Each wrap is an overflow event that sets a sticky timebase flag. A mode bit stretches the flag period to two wraps, which gives a slower periodic interrupt without a second counter. Software cannot read or load the count directly.

An external capture pin passes through a synchronizer. Every change of level on the pin, rising or falling, takes a snapshot of the count into a read-only capture register and sets a sticky capture flag. While that flag is set, later edges are dropped, so the register keeps the first unread snapshot.

Flags clear as a side effect of register reads. Two interrupt request outputs, one for the timebase and one for capture, follow the flags gated by their enables. The register port is a one-cycle read or write strobe with a one-bit address. Read data is combinational, and a read takes effect at the clock edge that ends the strobe cycle.

Top module: `timebase_capture`

## Requirements
- R1: After reset the count, prescaler, capture register, both flags and every control bit are zero, and both interrupt outputs are low.
- R2: The count advances once every 32 clocks and wraps from 249 (F9h) to 0. With the stretch bit clear, every wrap sets the timebase flag, so flag sets are exactly 8000 clocks apart.
- R3: With the stretch bit set, only every second wrap sets the timebase flag, so flag sets are 16000 clocks apart. Clearing the stretch bit resets the wrap pairing.
- R4: tbIrq is high exactly while both the timebase flag and the timebase enable are 1.
- R5: A read of address 0 clears the timebase flag at that clock edge. If an overflow event falls on the same edge, the flag stays 1.
- R6: Any level change on capPin, after a two-stage synchronizer, is detected once. If the capture flag is 0, the count present at the third clock edge after the pin change is stored in the capture register, and the capture flag is set.
- R7: capIrq is high exactly while both the capture flag and the capture enable are 1.
- R8: A read of address 1 clears the capture flag. A read of address 0 leaves the capture flag unchanged, and a read of address 1 leaves the timebase flag unchanged.
- R9: While the capture flag is 1, pin edges neither change the capture register nor produce a later capture.
- R10: Address 0 reads {000, stretch[4], tbFlag[3], tbEnable[2], capFlag[1], capEnable[0]}, and writes to it change only bits 4, 2 and 0. Address 1 returns the capture register, and writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capPin | input | 1 | Asynchronous capture input |
| regRdEn | input | 1 | Read strobe; clears flags at the edge |
| regWrEn | input | 1 | Write strobe |
| regAddr | input | 1 | 0 = control/status, 1 = capture |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| tbIrq | output | 1 | Timebase interrupt request |
| capIrq | output | 1 | Capture interrupt request |

## Verification
Capture is driven with a single rising edge, with a falling edge while the flag is still pending, and with a burst of one-cycle toggles. These patterns separate a correct edge detector and capture inhibit from designs that capture on only one polarity, that overwrite a pending snapshot, or that miss the inhibit. The timebase runs with the stretch bit clear and then set, and the spacing between interrupts tells a 250-count wrap from a 256-count wrap and from a missing stretch. A status read is placed exactly on a wrap edge to show that setting the flag wins over the read clear. Reads of each address check that each read clears only its own flag.

// File: rtl/timebase_capture_pkg.sv
`timescale 1ns/1ps
package timebase_capture_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capLoad;
    logic periodX2;
  } ctlStrobe_t;

  // events from datapath to control
  typedef struct packed {
    logic wrapEvt;
    logic ovfEvt;
    logic edgeSeen;
  } dpEvent_t;
endpackage

// File: rtl/tbc_datapath.sv
`timescale 1ns/1ps
module tbc_datapath
  import timebase_capture_pkg::*;
#(
  parameter int PRESCALE    = 32,
  parameter int CNT_W       = 8,
  parameter int WRAP_AT     = 249,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capPin,
  input  ctlStrobe_t       ctlStb,
  output dpEvent_t         dpEvt,
  output logic [CNT_W-1:0] capVal
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRAP_AT);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] baseCnt;
  logic             tick;
  logic             halfPhase;
  logic [SYNC_STAGES:0] pinPipe;

  assign tick = (preCnt == PRE_LAST);

  // prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  // timebase counter with short wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      baseCnt <= '0;
    else if (tick)
      baseCnt <= (baseCnt == CNT_LAST) ? '0 : baseCnt + 1'b1;
  end

  assign dpEvt.wrapEvt = tick && (baseCnt == CNT_LAST);

  // wrap pairing for the stretched period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 halfPhase <= 1'b0;
    else if (!ctlStb.periodX2) halfPhase <= 1'b0;
    else if (dpEvt.wrapEvt)    halfPhase <= ~halfPhase;
  end

  assign dpEvt.ovfEvt = dpEvt.wrapEvt && (!ctlStb.periodX2 || halfPhase);

  // synchronizer stages plus one history stage
  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pinPipe[gi] <= 1'b0;
        else if (gi == 0) pinPipe[gi] <= capPin;
        else pinPipe[gi] <= pinPipe[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign dpEvt.edgeSeen = pinPipe[SYNC_STAGES] ^ pinPipe[SYNC_STAGES-1];

  // capture latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              capVal <= '0;
    else if (ctlStb.capLoad) capVal <= baseCnt;
  end
endmodule

// File: rtl/tbc_control.sv
`timescale 1ns/1ps
module tbc_control
  import timebase_capture_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  dpEvent_t          dpEvt,
  input  logic [DATA_W-1:0] capVal,
  output ctlStrobe_t        ctlStb,
  output logic [DATA_W-1:0] regRdData,
  output logic              tbIrq,
  output logic              capIrq
);
  localparam int BIT_CAP_IE = 0;
  localparam int BIT_CAP_F  = 1;
  localparam int BIT_TB_IE  = 2;
  localparam int BIT_TB_F   = 3;
  localparam int BIT_X2     = 4;

  logic capIe, tbIe, periodX2;
  logic capFlag, tbFlag;
  logic rdStatus, rdCapture, wrStatus;

  assign rdStatus  = regRdEn && !regAddr;
  assign rdCapture = regRdEn &&  regAddr;
  assign wrStatus  = regWrEn && !regAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capIe    <= 1'b0;
      tbIe     <= 1'b0;
      periodX2 <= 1'b0;
    end else if (wrStatus) begin
      capIe    <= regWrData[BIT_CAP_IE];
      tbIe     <= regWrData[BIT_TB_IE];
      periodX2 <= regWrData[BIT_X2];
    end
  end

  assign ctlStb.capLoad  = dpEvt.edgeSeen && !capFlag;
  assign ctlStb.periodX2 = periodX2;

  // sticky flags: a set event wins over a read clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capFlag <= 1'b0;
      tbFlag  <= 1'b0;
    end else begin
      capFlag <= ctlStb.capLoad || (capFlag && !rdCapture);
      tbFlag  <= dpEvt.ovfEvt  || (tbFlag  && !rdStatus);
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) begin
      regRdData = capVal;
    end else begin
      regRdData[BIT_CAP_IE] = capIe;
      regRdData[BIT_CAP_F]  = capFlag;
      regRdData[BIT_TB_IE]  = tbIe;
      regRdData[BIT_TB_F]   = tbFlag;
      regRdData[BIT_X2]     = periodX2;
    end
  end

  assign tbIrq  = tbFlag  && tbIe;
  assign capIrq = capFlag && capIe;
endmodule

// File: rtl/timebase_capture.sv
`timescale 1ns/1ps
module timebase_capture
  import timebase_capture_pkg::*;
#(
  parameter int PRESCALE    = 32,
  parameter int CNT_W       = 8,
  parameter int WRAP_AT     = 249,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capPin,
  input  logic             regRdEn,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic             tbIrq,
  output logic             capIrq
);
  ctlStrobe_t       ctlStb;
  dpEvent_t         dpEvt;
  logic [CNT_W-1:0] capVal;

  tbc_datapath #(
    .PRESCALE(PRESCALE), .CNT_W(CNT_W), .WRAP_AT(WRAP_AT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .capPin(capPin),
    .ctlStb(ctlStb), .dpEvt(dpEvt), .capVal(capVal)
  );

  tbc_control #(.DATA_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .dpEvt(dpEvt), .capVal(capVal), .ctlStb(ctlStb),
    .regRdData(regRdData), .tbIrq(tbIrq), .capIrq(capIrq)
  );
endmodule

// File: rtl/timebase_capture_chk.sv
`timescale 1ns/1ps
module timebase_capture_chk
  import timebase_capture_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regRdEn,
  input logic             regWrEn,
  input logic             regAddr,
  input logic             tbIrq,
  input logic             capIrq,
  input ctlStrobe_t       ctlStb,
  input dpEvent_t         dpEvt,
  input logic [CNT_W-1:0] capVal
);
  // wraps are spaced by the prescaler, never on adjacent edges
  assert_wrap_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    dpEvt.wrapEvt |=> !dpEvt.wrapEvt);

  // a stretched overflow is always a wrap
  assert_ovf_is_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    dpEvt.ovfEvt |-> dpEvt.wrapEvt);

  // timebase request holds until a status read or an enable write
  assert_tbirq_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tbIrq && !(regRdEn && !regAddr) && !(regWrEn && !regAddr)) |=> tbIrq);

  // status read without a coincident wrap drops the timebase request
  assert_tbirq_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regAddr && !dpEvt.wrapEvt) |=> !tbIrq);

  // capture loads only on a detected edge
  assert_load_on_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.capLoad |-> dpEvt.edgeSeen);

  // capture request rises only from a load or an enable write
  assert_capirq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capIrq) |-> ($past(ctlStb.capLoad) || $past(regWrEn && !regAddr)));

  // capture read without an edge drops the capture request
  assert_capirq_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr && !dpEvt.edgeSeen) |=> !capIrq);

  // capture register only moves on a load
  assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctlStb.capLoad |=> $stable(capVal));
endmodule

bind timebase_capture timebase_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr),
  .tbIrq(tbIrq), .capIrq(capIrq), .ctlStb(ctlStb), .dpEvt(dpEvt), .capVal(capVal)
);

// File: tb/timebase_capture_bench.sv
`timescale 1ns/1ps
module timebase_capture_bench;
  localparam int PRE   = 32;
  localparam int WRAPV = 249;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       capPin = 1'b0;
  logic       regRdEn = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  wire  [7:0] regRdData;
  wire        tbIrq;
  wire        capIrq;

  int compared = 0;
  int mismatched = 0;
  int cycle = 0;
  bit done = 1'b0;

  // behavioural reference state
  int       mPre, mCnt;
  bit       mHalf, mS1, mS2, mS3;
  bit       mCapF, mTbF, mCapIe, mTbIe, mX2;
  bit [7:0] mCapV;
  bit       mEdge, mTick, mWrap, mEvt, mLoad;

  timebase_capture u_timebase_capture (
    .clk(clk), .rstN(rstN), .capPin(capPin),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .tbIrq(tbIrq), .capIrq(capIrq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cycle++;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; mHalf = 0; mS1 = 0; mS2 = 0; mS3 = 0;
      mCapF = 0; mTbF = 0; mCapIe = 0; mTbIe = 0; mX2 = 0; mCapV = 8'h00;
    end else begin
      mEdge = (mS2 != mS3);
      mTick = (mPre == PRE - 1);
      mWrap = mTick && (mCnt == WRAPV);
      mEvt  = mWrap && (!mX2 || mHalf);
      mLoad = mEdge && !mCapF;
      if (mLoad) mCapV = 8'(mCnt);
      mCapF = mLoad || (mCapF && !(regRdEn && regAddr));
      mTbF  = mEvt  || (mTbF  && !(regRdEn && !regAddr));
      if (!mX2) mHalf = 0; else if (mWrap) mHalf = !mHalf;
      if (regWrEn && !regAddr) begin
        mCapIe = regWrData[0]; mTbIe = regWrData[2]; mX2 = regWrData[4];
      end
      mS3 = mS2; mS2 = mS1; mS1 = capPin;
      if (mTick) begin
        mPre = 0;
        mCnt = (mCnt == WRAPV) ? 0 : mCnt + 1;
      end else begin
        mPre = mPre + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp,
                       input string what);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit [7:0] expRd();
    if (regAddr) return mCapV;
    return {3'b000, mX2, mTbF, mTbIe, mCapF, mCapIe};
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(tbIrq == (mTbF && mTbIe), "R4", int'(tbIrq), int'(mTbF && mTbIe), "tbIrq");
      check(capIrq == (mCapF && mCapIe), "R7", int'(capIrq), int'(mCapF && mCapIe), "capIrq");
      check(regRdData == expRd(), regAddr ? "R6" : "R10", int'(regRdData), int'(expRd()),
            "read data");
    end
  end

  always @(posedge clk) begin
    if (cycle == 190000 && !done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycle, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input bit a, input bit [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic regRead(input bit a, output bit [7:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    step();
    regRdEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic waitTb(output int t);
    while (!tbIrq) step();
    t = cycle;
  endtask

  initial begin
    bit [7:0] rd;
    bit [7:0] held;
    int t0, t1, t2;

    // R1: reset values
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tbIrq == 1'b0 && capIrq == 1'b0, "R1", int'({tbIrq, capIrq}), 0, "irqs in reset");
    check(regRdData == 8'h00, "R1", int'(regRdData), 0, "status in reset");
    @(posedge clk);
    #1 rstN = 1'b1;
    step();
    regRead(1'b1, rd);
    check(rd == 8'h00, "R1", int'(rd), 0, "capture after reset");

    regWrite(1'b0, 8'h05);

    // R6: single rising edge
    repeat (20) step();
    capPin = 1'b1;
    repeat (5) step();
    check(capIrq == 1'b1, "R6", int'(capIrq), 1, "capture flag after rising edge");
    regRead(1'b1, held);
    check(held == mCapV, "R6", int'(held), int'(mCapV), "captured count");
    // read of address 1 cleared the flag (R8)
    check(capIrq == 1'b0, "R8", int'(capIrq), 0, "capture flag after capture read");

    // R9: falling edge while a new capture is pending
    repeat (37) step();
    capPin = 1'b0;
    repeat (5) step();
    regRead(1'b1, held);
    capPin = 1'b1;
    repeat (70) step();
    capPin = 1'b0;
    repeat (6) step();
    regRead(1'b1, rd);
    check(rd == held, "R9", int'(rd), int'(held), "capture held while flag set");

    // R8: status read leaves capture flag set
    capPin = 1'b1;
    repeat (5) step();
    regRead(1'b0, rd);
    check(capIrq == 1'b1, "R8", int'(capIrq), 1, "capture flag after status read");
    regRead(1'b1, rd);
    check(capIrq == 1'b0, "R8", int'(capIrq), 0, "capture flag after capture read");

    // R6: burst of one-cycle toggles gives one capture
    for (int i = 0; i < 6; i++) begin
      capPin = ~capPin;
      step();
    end
    repeat (5) step();
    check(capIrq == 1'b1, "R6", int'(capIrq), 1, "capture flag after burst");
    regRead(1'b1, rd);
    repeat (5) step();
    regRead(1'b1, rd);

    // R10: write masks and write to capture address
    regWrite(1'b0, 8'hFF);
    regRead(1'b0, rd);
    check((rd & 8'hE0) == 8'h00 && rd[4] && rd[2] && rd[0], "R10", int'(rd), 8'h15,
          "status bits after all-ones write");
    regRead(1'b1, held);
    regWrite(1'b1, 8'hA5);
    regRead(1'b1, rd);
    check(rd == held, "R10", int'(rd), int'(held), "capture after write to address 1");
    regWrite(1'b0, 8'h05);

    // R2: plain period
    regRead(1'b0, rd);
    waitTb(t0); regRead(1'b0, rd);
    waitTb(t1); regRead(1'b0, rd);
    waitTb(t2); regRead(1'b0, rd);
    check(t1 - t0 == 8000, "R2", t1 - t0, 8000, "overflow spacing");
    check(t2 - t1 == 8000, "R2", t2 - t1, 8000, "overflow spacing");
    // R5 / R8: status read cleared the timebase flag, capture read does not
    check(tbIrq == 1'b0, "R5", int'(tbIrq), 0, "timebase flag after status read");

    // R5: status read on the wrap edge keeps the flag
    while (!(mPre == PRE - 1 && mCnt == WRAPV)) step();
    regRead(1'b0, rd);
    regRead(1'b0, rd);
    check(rd[3] == 1'b1, "R5", int'(rd[3]), 1, "flag when set and clear coincide");
    regRead(1'b1, held);
    check(tbIrq == 1'b0, "R8", int'(tbIrq), 0, "timebase flag after capture read");

    // R3: stretched period
    regWrite(1'b0, 8'h15);
    waitTb(t0); regRead(1'b0, rd);
    waitTb(t1); regRead(1'b0, rd);
    waitTb(t2); regRead(1'b0, rd);
    check(t1 - t0 == 16000, "R3", t1 - t0, 16000, "stretched spacing");
    check(t2 - t1 == 16000, "R3", t2 - t1, 16000, "stretched spacing");

    repeat (4) step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule